// File: doc/BRIEF.md
# PS/2 Keyboard Lock-Indicator Command Sequencer

This block is the host side of a PS/2 keyboard link, used only to set the keyboard's three lock indicators. A single-cycle request carries three indicator bits. The block claims the bus by holding the clock line low. It then sends the set-indicators command byte and waits for the keyboard's acknowledge byte. After that it sends the indicator mask byte and waits for a second acknowledge. The block never drives a line high. It only asserts pull-low enables, and an external open-drain pad turns each enable into a wired-AND line.

The block responds to a resend request and to a missing response. A resend request makes it send the last byte again. A missing response or a refused transfer starts the whole exchange over once. A second failure ends the exchange with an error pulse. A request that arrives during an exchange is held and carried out when the exchange ends. Parameters set the inhibit length and the response timeout in system clock cycles, so the block can be scaled to any clock rate.

Top module: `kbd_led_seq`

## Requirements
- R1: The block only ever asserts pull-low enables on the two lines. Once busy has been low for a full cycle, both enables are low.
- R2: Every byte transfer begins with the clock enable held for at least INHIBIT_CYC cycles. The data enable is asserted while the clock is still held, and the clock is released after that.
- R3: A byte goes out as a start 0, then eight data bits least significant first, then an odd parity bit, then a stop 1. A new bit is presented after each falling edge of the keyboard's clock, and the host releases data for the stop bit.
- R4: The first byte of an exchange is 0xED. After a valid 0xFA response, the second byte is the mask {5'b0, bit2 caps, bit1 num, bit0 scroll}, taken directly from led_bits[2:0].
- R5: A valid 0xFE response sends the same byte again (0xED or the mask), with no change of phase.
- R6: If no valid 0xFA or 0xFE arrives within TMO_CYC cycles of a byte's launch, the exchange restarts from 0xED once. The second such failure gives a one-cycle error pulse, and the block returns to idle.
- R7: done is a one-cycle pulse after the 0xFA that answers the mask byte. busy is high from the start of the exchange until that pulse, and done and error are never high together.
- R8: A request made while busy is latched, with the latest bits winning. It does not disturb the current exchange, and it starts its own exchange when the current one ends.
- R9: During reset and right after it, both enables, busy, done and error are low.
- R10: While waiting for a response, a received byte other than 0xFA or 0xFE, or a frame with a bad start bit, parity or stop bit, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| led_req | input | 1 | One-cycle request to set the indicators |
| led_bits | input | 3 | Indicator bits: bit0 scroll, bit1 num, bit2 caps |
| ps2_clk_i | input | 1 | Raw PS/2 clock line level |
| ps2_data_i | input | 1 | Raw PS/2 data line level |
| ps2_clk_oe | output | 1 | Pull PS/2 clock line low when 1 |
| ps2_data_oe | output | 1 | Pull PS/2 data line low when 1 |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse: exchange completed |
| error | output | 1 | One-cycle pulse: exchange abandoned after retry |

## Verification
A wrong phase or byte pointer in the sequencer shows up at the data enable within one keyboard clock period. The bench's keyboard model decodes every bit as it is presented and compares the full frame as soon as the stop bit arrives. A faulty bit counter or shift register in the transmitter breaks parity or the stop bit of the very first frame. A retry, resend or pending-latch fault shows up as a wrong byte at the next bus claim, or as a done or error pulse that is missing or extra after the closing response. A timeout fault shows up TMO_CYC cycles after the silent byte.

// File: rtl/kbd_led_pkg.sv
package kbd_led_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_TX,
    SQ_WAIT
  } seq_st_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_INHIBIT,
    TX_REQ,
    TX_SHIFT
  } tx_st_t;

  localparam logic [7:0] CMD_SET_IND = 8'hED;
  localparam logic [7:0] RSP_ACK     = 8'hFA;
  localparam logic [7:0] RSP_RESEND  = 8'hFE;

  function automatic logic odd_par(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk_i,
  input  logic line_data_i,
  output logic data_s,
  output logic clk_fall
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic              clk_prev_q;

  assign raw = {line_data_i, line_clk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b1;
    else        clk_prev_q <= synced[0];
  end

  assign data_s   = synced[1];
  assign clk_fall = clk_prev_q & ~synced[0];

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import kbd_led_pkg::*;
#(
  parameter int INHIBIT_CYC = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start,
  input  logic [7:0] byte_i,
  input  logic       clk_fall,
  input  logic       data_s,
  output logic       clk_oe,
  output logic       data_oe,
  output logic       done,
  output logic       ack_ok
);
  localparam int CW = $clog2(INHIBIT_CYC + 1);
  localparam int NB = 10;

  tx_st_t          st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [NB-1:0]   sh_q, sh_n;
  logic [3:0]      bitn_q, bitn_n;
  logic            clk_oe_q, clk_oe_n;
  logic            data_oe_q, data_oe_n;
  logic            done_q, done_n;
  logic            ack_q, ack_n;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    bitn_n    = bitn_q;
    clk_oe_n  = clk_oe_q;
    data_oe_n = data_oe_q;
    done_n    = 1'b0;
    ack_n     = ack_q;
    if (!en) begin
      st_n      = TX_IDLE;
      clk_oe_n  = 1'b0;
      data_oe_n = 1'b0;
    end else if (start) begin
      st_n      = TX_INHIBIT;
      cnt_n     = '0;
      clk_oe_n  = 1'b1;
      data_oe_n = 1'b0;
      sh_n      = {1'b1, odd_par(byte_i), byte_i};
      bitn_n    = '0;
    end else begin
      case (st_q)
        TX_INHIBIT: begin
          if (cnt_q == CW'(INHIBIT_CYC - 1)) begin
            st_n      = TX_REQ;
            data_oe_n = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        TX_REQ: begin
          clk_oe_n = 1'b0;
          st_n     = TX_SHIFT;
        end
        TX_SHIFT: begin
          if (clk_fall) begin
            if (bitn_q != 4'(NB)) begin
              data_oe_n = ~sh_q[0];
              sh_n      = {1'b0, sh_q[NB-1:1]};
              bitn_n    = bitn_q + 1'b1;
            end else begin
              ack_n     = ~data_s;
              done_n    = 1'b1;
              data_oe_n = 1'b0;
              st_n      = TX_IDLE;
            end
          end
        end
        default: begin
          clk_oe_n  = 1'b0;
          data_oe_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= TX_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      bitn_q    <= '0;
      clk_oe_q  <= 1'b0;
      data_oe_q <= 1'b0;
      done_q    <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      sh_q      <= sh_n;
      bitn_q    <= bitn_n;
      clk_oe_q  <= clk_oe_n;
      data_oe_q <= data_oe_n;
      done_q    <= done_n;
      ack_q     <= ack_n;
    end
  end

  assign clk_oe  = clk_oe_q;
  assign data_oe = data_oe_q;
  assign done    = done_q;
  assign ack_ok  = ack_q;

  // Checker: length of the current clock-hold run, kept apart from the FSM counter
  logic [CW:0] chk_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chk_run_q <= '0;
    else if (clk_oe_q) chk_run_q <= chk_run_q + 1'b1;
    else               chk_run_q <= '0;
  end

  a_r2_inhibit_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_oe_q) && clk_oe_q) |-> (chk_run_q >= (CW+1)'(INHIBIT_CYC)));

  a_r3_bits_follow_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_SHIFT && $past(st_q) == TX_SHIFT && data_oe_q != $past(data_oe_q))
      |-> $past(clk_fall));

endmodule

// File: rtl/ps2_dev_rx.sv
module ps2_dev_rx
  import kbd_led_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clk_fall,
  input  logic       data_s,
  output logic       valid,
  output logic [7:0] byte_o,
  output logic       frame_ok
);
  localparam int NF = 11;

  logic [NF-1:0] sh_q, sh_n;
  logic [3:0]    cnt_q, cnt_n;
  logic          valid_q, valid_n;
  logic          ok_q, ok_n;
  logic [NF-1:0] full;

  assign full = {data_s, sh_q[NF-1:1]};

  always_comb begin
    sh_n    = sh_q;
    cnt_n   = cnt_q;
    valid_n = 1'b0;
    ok_n    = ok_q;
    if (!en) begin
      cnt_n = '0;
    end else if (clk_fall) begin
      sh_n = full;
      if (cnt_q == 4'(NF - 1)) begin
        cnt_n   = '0;
        valid_n = 1'b1;
        ok_n    = ~full[0] & full[NF-1] & (full[9] == odd_par(full[8:1]));
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      sh_q    <= sh_n;
      cnt_q   <= cnt_n;
      valid_q <= valid_n;
      ok_q    <= ok_n;
    end
  end

  assign valid    = valid_q;
  assign frame_ok = ok_q;
  assign byte_o   = sh_q[8:1];

  a_r10_rx_only_when_listening: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(en));

endmodule

// File: rtl/kbd_led_seq.sv
module kbd_led_seq
  import kbd_led_pkg::*;
#(
  parameter int INHIBIT_CYC = 20000,
  parameter int TMO_CYC     = 4000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       led_req,
  input  logic [2:0] led_bits,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       ps2_clk_oe,
  output logic       ps2_data_oe,
  output logic       busy,
  output logic       done,
  output logic       error
);
  localparam int TW = $clog2(TMO_CYC + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sh_q;
  logic       rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rs_n = rst_sh_q[1];

  seq_st_t       st_q, st_n;
  logic          pend_q, pend_n;
  logic [2:0]    pbits_q, pbits_n;
  logic [2:0]    cbits_q, cbits_n;
  logic          phase_q, phase_n;
  logic          retried_q, retried_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic          done_q, done_n;
  logic          err_q, err_n;

  logic       data_s, clk_fall;
  logic       tx_en, tx_start, tx_done, tx_ack;
  logic       rx_valid, rx_ok;
  logic [7:0] rx_byte, cur_byte;
  logic       tmo_hit, rsp_ack, rsp_resend, fail;

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rs_n),
    .line_clk_i(ps2_clk_i), .line_data_i(ps2_data_i),
    .data_s(data_s), .clk_fall(clk_fall)
  );

  assign tx_start = (st_q == SQ_LAUNCH);
  assign tx_en    = (st_q == SQ_LAUNCH) || (st_q == SQ_TX);
  assign cur_byte = phase_q ? {5'b0, cbits_q} : CMD_SET_IND;

  ps2_host_tx #(.INHIBIT_CYC(INHIBIT_CYC)) u_tx (
    .clk(clk), .rst_n(rs_n), .en(tx_en), .start(tx_start), .byte_i(cur_byte),
    .clk_fall(clk_fall), .data_s(data_s),
    .clk_oe(ps2_clk_oe), .data_oe(ps2_data_oe), .done(tx_done), .ack_ok(tx_ack)
  );

  ps2_dev_rx u_rx (
    .clk(clk), .rst_n(rs_n), .en(st_q == SQ_WAIT), .clk_fall(clk_fall),
    .data_s(data_s), .valid(rx_valid), .byte_o(rx_byte), .frame_ok(rx_ok)
  );

  assign tmo_hit    = (tmr_q == TW'(TMO_CYC - 1));
  assign rsp_ack    = rx_valid && rx_ok && (rx_byte == RSP_ACK);
  assign rsp_resend = rx_valid && rx_ok && (rx_byte == RSP_RESEND);

  always_comb begin
    fail = 1'b0;
    case (st_q)
      SQ_TX:   fail = tx_done ? !tx_ack : tmo_hit;
      SQ_WAIT: fail = !rsp_ack && !rsp_resend && tmo_hit;
      default: fail = 1'b0;
    endcase
  end

  always_comb begin
    st_n      = st_q;
    pend_n    = pend_q;
    pbits_n   = pbits_q;
    cbits_n   = cbits_q;
    phase_n   = phase_q;
    retried_n = retried_q;
    tmr_n     = tmr_q;
    done_n    = 1'b0;
    err_n     = 1'b0;

    if (st_q == SQ_IDLE && pend_q) pend_n = 1'b0;
    if (led_req) begin
      pend_n  = 1'b1;
      pbits_n = led_bits;
    end

    case (st_q)
      SQ_IDLE: begin
        if (pend_q) begin
          cbits_n   = pbits_q;
          phase_n   = 1'b0;
          retried_n = 1'b0;
          st_n      = SQ_LAUNCH;
        end
      end
      SQ_LAUNCH: begin
        tmr_n = '0;
        st_n  = SQ_TX;
      end
      SQ_TX: begin
        tmr_n = tmr_q + 1'b1;
        if (tx_done && tx_ack) st_n = SQ_WAIT;
      end
      SQ_WAIT: begin
        tmr_n = tmr_q + 1'b1;
        if (rsp_ack) begin
          if (!phase_q) begin
            phase_n = 1'b1;
            st_n    = SQ_LAUNCH;
          end else begin
            done_n = 1'b1;
            st_n   = SQ_IDLE;
          end
        end else if (rsp_resend) begin
          st_n = SQ_LAUNCH;
        end
      end
      default: st_n = SQ_IDLE;
    endcase

    if (fail) begin
      if (!retried_q) begin
        retried_n = 1'b1;
        phase_n   = 1'b0;
        st_n      = SQ_LAUNCH;
      end else begin
        err_n = 1'b1;
        st_n  = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q      <= SQ_IDLE;
      pend_q    <= 1'b0;
      pbits_q   <= '0;
      cbits_q   <= '0;
      phase_q   <= 1'b0;
      retried_q <= 1'b0;
      tmr_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      pend_q    <= pend_n;
      pbits_q   <= pbits_n;
      cbits_q   <= cbits_n;
      phase_q   <= phase_n;
      retried_q <= retried_n;
      tmr_q     <= tmr_n;
      done_q    <= done_n;
      err_q     <= err_n;
    end
  end

  assign busy  = (st_q != SQ_IDLE);
  assign done  = done_q;
  assign error = err_q;

  a_r1_lines_free_when_idle: assert property (@(posedge clk) disable iff (!rs_n)
    (!busy && !$past(busy)) |-> (!ps2_clk_oe && !ps2_data_oe));

  a_r7_done_not_error: assert property (@(posedge clk) disable iff (!rs_n)
    done |-> !error);

  a_r7_done_ends_exchange: assert property (@(posedge clk) disable iff (!rs_n)
    done |-> $past(busy));

  a_r6_error_returns_idle: assert property (@(posedge clk) disable iff (!rs_n)
    error |-> (!busy && $past(busy)));

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rs_n)
    (busy && led_req) |=> pend_q);

endmodule

// File: tb/sim_kbd_led_seq.sv
`timescale 1ns/1ps
module sim_kbd_led_seq;
  localparam int INH  = 40;
  localparam int TMO  = 6000;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic led_req = 1'b0;
  logic [2:0] led_bits = '0;
  logic dev_clk_low = 1'b0;
  logic dev_data_low = 1'b0;
  logic clk_oe, data_oe, busy, done, error;
  logic bus_clk, bus_data;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  int claim_cnt = 0;
  int run = 0;
  int last_inh = 0;
  logic prev_busy = 1'b0;
  logic prev_clk_oe = 1'b0;
  logic prev_data_oe = 1'b0;

  always #2.5 clk = ~clk;

  assign bus_clk  = ~(clk_oe | dev_clk_low);
  assign bus_data = ~(data_oe | dev_data_low);

  kbd_led_seq #(.INHIBIT_CYC(INH), .TMO_CYC(TMO), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .led_req(led_req), .led_bits(led_bits),
    .ps2_clk_i(bus_clk), .ps2_data_i(bus_data),
    .ps2_clk_oe(clk_oe), .ps2_data_oe(data_oe),
    .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle reference: bus-claim length, pulse counts, idle line state
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (error) err_cnt++;
      if (clk_oe && !prev_clk_oe) claim_cnt++;
      if (data_oe && !prev_data_oe && clk_oe) last_inh = run;
      if (clk_oe) run++; else run = 0;
      if (!busy && !prev_busy && (clk_oe || data_oe)) begin
        errors++;
        $display("FAIL R1 actual=%0h expected=0", {clk_oe, data_oe});
      end
      if (done && error) begin
        errors++;
        $display("FAIL R7 actual=%0h expected=0", {done, error});
      end
      prev_busy = busy;
      prev_clk_oe = clk_oe;
      prev_data_oe = data_oe;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input logic [2:0] v);
    @(negedge clk);
    led_req = 1'b1;
    led_bits = v;
    @(negedge clk);
    led_req = 1'b0;
  endtask

  task automatic wait_claim(output bit got);
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (data_oe && !clk_oe) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  // Keyboard model: clocks one host byte in, checks framing, drives line ack
  task automatic kbd_recv(output logic [7:0] b, input string req);
    bit got;
    logic [9:0] bits;
    logic start_lvl;
    wait_claim(got);
    chk(got, "R2 claim", got, 1);
    chk(last_inh >= INH, "R2 inhibit", last_inh, INH);
    cyc(HALF);
    start_lvl = bus_data;
    chk(start_lvl == 1'b0, "R3 start", start_lvl, 0);
    for (int i = 0; i < 10; i++) begin
      dev_clk_low = 1'b1;
      cyc(HALF);
      dev_clk_low = 1'b0;
      cyc(HALF);
      bits[i] = bus_data;
    end
    chk((^bits[8:0]) == 1'b1, {req, " parity"}, bits[8], ~^bits[7:0]);
    chk(bits[9] == 1'b1, "R3 stop", bits[9], 1);
    dev_data_low = 1'b1;
    cyc(4);
    dev_clk_low = 1'b1;
    cyc(HALF);
    dev_clk_low = 1'b0;
    cyc(4);
    dev_data_low = 1'b0;
    b = bits[7:0];
  endtask

  task automatic kbd_send(input logic [7:0] b, input bit bad_par);
    logic [10:0] f;
    f = {1'b1, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      dev_data_low = ~f[i];
      cyc(HALF / 2);
      dev_clk_low = 1'b1;
      cyc(HALF);
      dev_clk_low = 1'b0;
      cyc(HALF / 2);
    end
    dev_data_low = 1'b0;
  endtask

  task automatic finish_up;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    logic [7:0] b;
    bit got;
    int d0, e0, c0;

    cyc(3);
    chk({clk_oe, data_oe, busy, done, error} == 5'b0, "R9 in reset",
        {clk_oe, data_oe, busy, done, error}, 0);
    rst_n = 1'b1;
    cyc(5);
    chk({clk_oe, data_oe, busy, done, error} == 5'b0, "R9 after reset",
        {clk_oe, data_oe, busy, done, error}, 0);

    // R4 R7: plain exchange, scroll and caps set
    d0 = done_cnt;
    request(3'b101);
    cyc(2);
    chk(busy, "R7 busy", busy, 1);
    kbd_recv(b, "R3");
    chk(b == 8'hED, "R4 command", b, 8'hED);
    kbd_send(8'hFA, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'h05, "R4 mask", b, 8'h05);
    chk(busy, "R7 busy mid", busy, 1);
    kbd_send(8'hFA, 1'b0);
    cyc(5);
    chk(done_cnt == d0 + 1, "R7 done", done_cnt, d0 + 1);
    chk(!busy, "R7 idle", busy, 0);

    // R5: resend on both bytes
    d0 = done_cnt;
    request(3'b010);
    kbd_recv(b, "R3");
    kbd_send(8'hFE, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'hED, "R5 command again", b, 8'hED);
    kbd_send(8'hFA, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'h02, "R4 mask num", b, 8'h02);
    kbd_send(8'hFE, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'h02, "R5 mask again", b, 8'h02);
    kbd_send(8'hFA, 1'b0);
    cyc(5);
    chk(done_cnt == d0 + 1, "R5 done", done_cnt, d0 + 1);

    // R10: stray byte and bad-parity acknowledge are ignored
    d0 = done_cnt;
    request(3'b111);
    kbd_recv(b, "R3");
    kbd_send(8'hAA, 1'b0);
    c0 = claim_cnt;
    kbd_send(8'hFA, 1'b1);
    cyc(200);
    chk(claim_cnt == c0, "R10 no claim", claim_cnt, c0);
    chk(busy, "R10 still busy", busy, 1);
    kbd_send(8'hFA, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'h07, "R10 mask after valid ack", b, 8'h07);
    kbd_send(8'hFA, 1'b0);
    cyc(5);
    chk(done_cnt == d0 + 1, "R10 done", done_cnt, d0 + 1);

    // R6: one silent response, then success
    d0 = done_cnt;
    e0 = err_cnt;
    request(3'b001);
    kbd_recv(b, "R3");
    kbd_recv(b, "R3");
    chk(b == 8'hED, "R6 retry from command", b, 8'hED);
    kbd_send(8'hFA, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'h01, "R6 mask", b, 8'h01);
    kbd_send(8'hFA, 1'b0);
    cyc(5);
    chk(done_cnt == d0 + 1 && err_cnt == e0, "R6 done no error", err_cnt, e0);

    // R6: two failures give error
    d0 = done_cnt;
    e0 = err_cnt;
    request(3'b100);
    kbd_recv(b, "R3");
    wait_claim(got);
    chk(got, "R6 second attempt", got, 1);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (err_cnt != e0) break;
    end
    cyc(3);
    chk(err_cnt == e0 + 1, "R6 error pulse", err_cnt, e0 + 1);
    chk(done_cnt == d0, "R6 no done", done_cnt, d0);
    chk({busy, clk_oe, data_oe} == 3'b0, "R6 released", {busy, clk_oe, data_oe}, 0);

    // R8: requests during an exchange are held, latest wins
    d0 = done_cnt;
    request(3'b011);
    kbd_recv(b, "R3");
    request(3'b110);
    request(3'b100);
    kbd_send(8'hFA, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'h03, "R8 current unaffected", b, 8'h03);
    kbd_send(8'hFA, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'hED, "R8 pending started", b, 8'hED);
    chk(done_cnt == d0 + 1, "R8 first done", done_cnt, d0 + 1);
    kbd_send(8'hFA, 1'b0);
    kbd_recv(b, "R3");
    chk(b == 8'h04, "R8 latest bits", b, 8'h04);
    kbd_send(8'hFA, 1'b0);
    cyc(5);
    chk(done_cnt == d0 + 2, "R8 second done", done_cnt, d0 + 2);
    chk(!busy, "R8 idle", busy, 0);

    cyc(10);
    finish_up();
  end

endmodule